// File: doc/BRIEF.md
# Fast Clock Divider with Selectable Output Clock

This block runs on the converter's fast sampling clock and derives from it a family of slower clocks. A single free-running binary counter provides the fast clock divided by 2, 4, 8 and 16, with each divided clock taken straight from one counter bit. One low-speed clock leaves the block for the downstream logic that captures the parallel data. A three-bit code picks its rate from the /4, /8 and /16 taps, and one bit of that code inverts its polarity.

The fast clock comes either from an on-chip clock multiplier or from an external high-speed clock input. A mode input tells the block which source is in use. When the external source is in use, an active-high alignment request clears the counter. Several converters that share one external clock and one request line then start their divided clocks on the same fast-clock edge.

The alignment request is synchronized to the fast clock before it acts. A new output-clock code is adopted only where the counter wraps to zero. At that point every tap is low, so a rate change never produces a short pulse.

Top module: `fclk_divider`

## Requirements
- R1: While `rst_n` is low, `div_clk` and `lo_clk_out` are all zero.
- R2: Outside an alignment clear, `div_clk` advances by exactly one (modulo 16) on every rising edge of `clk_fast`. Bit k is therefore the fast clock divided by 2^(k+1).
- R3: With `out_sel[1]`=1 and `out_sel[0]`=1, `lo_clk_out` follows `div_clk[1]` (the /4 clock).
- R4: With `out_sel[1]`=1 and `out_sel[0]`=0, `lo_clk_out` follows `div_clk[2]` (the /8 clock).
- R5: With `out_sel[1]`=0, `lo_clk_out` follows `div_clk[3]` (the /16 clock), whatever the value of `out_sel[0]`.
- R6: With `out_sel[2]`=1, `lo_clk_out` is the complement of the chosen tap. With `out_sel[2]`=0, it equals the chosen tap.
- R7: A new `out_sel` value takes effect on the edge where `div_clk` wraps to zero. Until that edge, the previous selection stays in force.
- R8: With `pll_mode`=0, an `align_req` held high clears `div_clk` to zero from the third rising edge after it is raised, and holds it at zero while it stays high.
- R9: With `pll_mode`=1, `align_req` has no effect and `div_clk` keeps counting.
- R10: After `align_req` is lowered, `div_clk` stays zero for two more edges. It reads 1 after the third edge.
- R11: Every divided clock and `lo_clk_out` have a 50% duty cycle. For example, the /8 clock is high for exactly 16 of any 32 consecutive fast-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast sampling clock (already muxed from its source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_mode | input | 1 | 1 = clock from on-chip multiplier, 0 = external high-speed clock |
| align_req | input | 1 | Active-high divider alignment request, asynchronous |
| out_sel | input | 3 | [0] /4 vs /8 pick, [1] 0 = /16, [2] invert |
| div_clk | output | 4 | Divided clocks: bit k = fast clock / 2^(k+1) |
| lo_clk_out | output | 1 | Selected low-speed output clock |

## Verification
If the counter holds a wrong value, `div_clk` shows it on the very next cycle, because the step of exactly one per edge is broken. A wrong stored selection or polarity makes `lo_clk_out` part from the expected tap within one /16 period. The bench checks this against the `div_clk` bits at every cycle. A wrong alignment pipeline shows up as a clear that arrives one edge early or late, or that fires in multiplier mode, and the bench checks the exact edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Output clock selection code; bit order matches out_sel[2:0].
  typedef struct packed {
    logic inv;       // out_sel[2]: invert the chosen tap
    logic fast_grp;  // out_sel[1]: 1 = /4 or /8, 0 = slowest tap
    logic quarter;   // out_sel[0]: within fast group, 1 = /4, 0 = /8
  } osel_t;

  // Counter bit index that carries the clock picked by a selection code.
  function automatic int unsigned tap_of(osel_t s, int unsigned slow_tap);
    if (!s.fast_grp)   return slow_tap;
    else if (s.quarter) return 1;
    else                return 2;
  endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned NSTG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [NSTG-1:0] cnt_q,
  output logic [NSTG-1:0] cnt_d
);
  assign cnt_d = clr ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: an active clear leaves the counter at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R2: the /2 tap toggles on every edge outside a clear
  p_half_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q[0] != $past(cnt_q[0])));

  // R2 / R11: a higher tap moves only when all lower bits were ones
  for (genvar k = 1; k < NSTG; k++) begin : g_tap_chk
    p_tap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(&cnt_q[k-1:0])) |=> $stable(cnt_q[k]));
  end
endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel
  import clkdiv_pkg::*;
#(
  parameter int unsigned NSTG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] cnt_q,
  input  logic [NSTG-1:0] cnt_d,
  input  osel_t           sel_in,
  output osel_t           sel_act,
  output logic            clk_out
);
  localparam int unsigned SLOW_TAP = NSTG - 1;

  logic  wrap_evt;   // counter enters zero on this edge
  osel_t sel_nx;
  logic  out_nx;

  assign wrap_evt = (cnt_d == '0);
  assign sel_nx   = wrap_evt ? sel_in : sel_act;
  assign out_nx   = cnt_d[tap_of(sel_nx, SLOW_TAP)] ^ sel_nx.inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_act <= '0;
      clk_out <= 1'b0;
    end else begin
      sel_act <= sel_nx;
      clk_out <= out_nx;
    end
  end

  // R7: selection is held between wraps and adopted at a wrap
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(sel_act));
  p_sel_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (sel_act == $past(sel_in)));

  // R3 / R6: /4 tap
  p_quarter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act.fast_grp && sel_act.quarter) |-> (clk_out == (cnt_q[1] ^ sel_act.inv)));
  // R4 / R6: /8 tap
  p_eighth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act.fast_grp && !sel_act.quarter) |-> (clk_out == (cnt_q[2] ^ sel_act.inv)));
  // R5 / R6: slowest tap, pick bit ignored
  p_slowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act.fast_grp |-> (clk_out == (cnt_q[SLOW_TAP] ^ sel_act.inv)));
endmodule

// File: rtl/fclk_divider.sv
module fclk_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned NSTG     = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic            clk_fast,
  input  logic            rst_n,
  input  logic            pll_mode,
  input  logic            align_req,
  input  logic [2:0]      out_sel,
  output logic [NSTG-1:0] div_clk,
  output logic            lo_clk_out
);
  logic            align_s;    // synchronized request
  logic            clear_evt;  // request honoured in external-clock mode
  logic [NSTG-1:0] cnt_q;
  logic [NSTG-1:0] cnt_d;
  osel_t           sel_act;

  clkdiv_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .d     (align_req),
    .q     (align_s)
  );

  assign clear_evt = align_s & ~pll_mode;

  clkdiv_counter #(.NSTG(NSTG)) u_cnt (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .clr   (clear_evt),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  clkdiv_outsel #(.NSTG(NSTG)) u_osel (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d),
    .sel_in  (osel_t'(out_sel)),
    .sel_act (sel_act),
    .clk_out (lo_clk_out)
  );

  assign div_clk = cnt_q;

  // R9: in multiplier mode the request never disturbs the count
  p_mode_ignore_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    pll_mode |=> (div_clk == NSTG'($past(div_clk) + 1'b1)));

  // R8: a synchronized request in external mode clears the taps
  p_ext_align_r8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (align_s && !pll_mode) |=> (div_clk == '0));
endmodule

// File: tb/sim_fclk_divider.sv
module sim_fclk_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk_fast = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_mode = 1'b1;
  logic       align_req = 1'b0;
  logic [2:0] out_sel = 3'b000;
  logic [3:0] div_clk;
  logic       lo_clk_out;

  int checks = 0;
  int errors = 0;

  fclk_divider u0 (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .pll_mode   (pll_mode),
    .align_req  (align_req),
    .out_sel    (out_sel),
    .div_clk    (div_clk),
    .lo_clk_out (lo_clk_out)
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected output from a code, written as a table rather than a tap index.
  function automatic logic exp_lo(input logic [2:0] code, input logic [3:0] c);
    logic b;
    case (code[1:0])
      2'b11:   b = c[1];
      2'b10:   b = c[2];
      default: b = c[3];
    endcase
    return b ^ code[2];
  endfunction

  task automatic wait_wrap();
    do @(negedge clk_fast); while (div_clk != 4'd0);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2);
    chk(div_clk == 4'd0, "R1 div_clk in reset", div_clk, 0);
    chk(lo_clk_out == 1'b0, "R1 lo_clk_out in reset", lo_clk_out, 0);
    @(negedge clk_fast);
    rst_n = 1'b1;
    @(negedge clk_fast);
    chk(div_clk == 4'd1, "R2 first count after reset", div_clk, 1);
  endtask

  task automatic t_count();
    logic [3:0] prev;
    prev = div_clk;
    for (int i = 0; i < 34; i++) begin
      @(negedge clk_fast);
      chk(div_clk == 4'(prev + 1), "R2 step of one", div_clk, 4'(prev + 1));
      prev = div_clk;
    end
  endtask

  task automatic t_select(input logic [2:0] code, input string req);
    int bad = 0;
    out_sel = code;
    wait_wrap();
    for (int i = 0; i < 32; i++) begin
      if (lo_clk_out != exp_lo(code, div_clk)) bad++;
      @(negedge clk_fast);
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_duty(input logic [2:0] code, input string req);
    int hi = 0;
    out_sel = code;
    wait_wrap();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_fast);
      hi += int'(lo_clk_out);
    end
    chk(hi == 16, req, hi, 16);
  endtask

  task automatic t_tap_duty();
    int hi [4] = '{0, 0, 0, 0};
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_fast);
      for (int k = 0; k < 4; k++) hi[k] += int'(div_clk[k]);
    end
    for (int k = 0; k < 4; k++) chk(hi[k] == 16, "R11 tap duty", hi[k], 16);
  endtask

  task automatic t_midchange();
    bit seen = 0;
    int bad_old = 0;
    int bad_new = 0;
    out_sel = 3'b000;
    wait_wrap();
    do @(negedge clk_fast); while (div_clk != 4'd5);
    out_sel = 3'b011;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_fast);
      if (div_clk == 4'd0) seen = 1;
      if (!seen && lo_clk_out != div_clk[3]) bad_old++;
      if (seen && lo_clk_out != div_clk[1]) bad_new++;
    end
    chk(bad_old == 0, "R7 old select held until wrap", bad_old, 0);
    chk(bad_new == 0, "R7 new select from wrap", bad_new, 0);
  endtask

  task automatic t_align_ext();
    pll_mode = 1'b0;
    out_sel = 3'b000;
    wait_wrap();
    repeat (3) @(negedge clk_fast);
    align_req = 1'b1;
    @(negedge clk_fast);
    @(negedge clk_fast);
    chk(div_clk == 4'd5, "R8 no clear before third edge", div_clk, 5);
    @(negedge clk_fast);
    chk(div_clk == 4'd0, "R8 clear at third edge", div_clk, 0);
    repeat (6) @(negedge clk_fast);
    chk(div_clk == 4'd0, "R8 held at zero", div_clk, 0);
    chk(lo_clk_out == 1'b0, "R8 output low while held", lo_clk_out, 0);
    align_req = 1'b0;
    @(negedge clk_fast);
    @(negedge clk_fast);
    chk(div_clk == 4'd0, "R10 still zero two edges after release", div_clk, 0);
    @(negedge clk_fast);
    chk(div_clk == 4'd1, "R10 counting resumes", div_clk, 1);
    pll_mode = 1'b1;
  endtask

  task automatic t_align_pll();
    logic [3:0] prev;
    int bad = 0;
    pll_mode = 1'b1;
    align_req = 1'b1;
    prev = div_clk;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_fast);
      if (div_clk != 4'(prev + 1)) bad++;
      prev = div_clk;
    end
    align_req = 1'b0;
    chk(bad == 0, "R9 request ignored in multiplier mode", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_tap_duty();
    t_select(3'b011, "R3 /4 select");
    t_select(3'b010, "R4 /8 select");
    t_select(3'b000, "R5 /16 select pick 0");
    t_select(3'b001, "R5 /16 select pick 1");
    t_select(3'b111, "R6 inverted /4");
    t_select(3'b100, "R6 inverted /16");
    t_duty(3'b010, "R11 output /8 duty");
    t_duty(3'b110, "R11 inverted /8 duty");
    t_midchange();
    t_align_ext();
    t_align_pll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule